// File: doc/BRIEF.md
# Memory Region Access Filter

This block stands in front of one memory slave and decides, access by access, whether a request may proceed. Software programs a set of base regions. Each base region has an address window and three per-compartment whitelists: one for reads, one for writes and one that forces privilege. Each base region also holds two nested subregions. A subregion, when enabled, overrides its parent for the addresses it covers and admits exactly one compartment.

The allow decision is combinational from the access inputs and the stored configuration. The first illegal access, whether a data access or a configuration access, is recorded in a syndrome record behind a sticky flag, and a one-cycle interrupt pulse follows. A global lock and a per-subregion lock each freeze configuration until reset.

The configuration port is a single-cycle request. `cfg_addr[7:4]` selects a region slice, with value 15 selecting the global block, and `cfg_addr[3:0]` selects a register. Reads return data on `cfg_rdata` in the same cycle.

Top module: `mrf_filter`

## Requirements
- R1: After reset every region and subregion is disabled, both error flags and the global lock read 0, and every data access is denied.
- R2: A base region matches when its enable bit is set and start <= address <= end, both inclusive. When several regions match, the lowest region index decides. An address that matches no enabled region is denied.
- R3: A start address written to register 1 (base), 5 (subregion A) or 8 (subregion B) is stored with its low GRAN_BITS bits cleared. An end address written to register 2, 6 or 9 is stored with those bits set.
- R4: Writes to a base region's start or end registers are ignored while its enable bit is set. Writing region register 0 with bit 0 clear clears only the enable bit; the secure bit and the privilege whitelist keep their values.
- R5: Base permission has three conditions. Region register 0 holds enable in bit 0, secure in bit 1 and the privilege whitelist in bits 15:8. Register 3 holds the read whitelist in bits 7:0 and the write whitelist in bits 15:8. A secure region admits only secure accesses. The access's compartment bit must be set in the read or write whitelist that matches its direction. If that compartment's bit is set in the privilege whitelist, the access must also be privileged.
- R6: Subregion configuration registers are 4 (A) and 7 (B). Their bits are: 0 enable, 1 secure, 2 privileged, 3 read-enable, 4 write-enable, 5 lock, and 10:8 the compartment ID. An enabled subregion whose window covers the address overrides its base region, and A takes precedence over B. A subregion admits an access only under four conditions: the compartment ID matches; the access is secure if the subregion's secure bit is set; the access is privileged if its privileged bit is set; and the matching read-enable or write-enable bit is set.
- R7: Once a subregion's lock bit is set, writes to that subregion's three registers are ignored until reset. A subregion's start and end registers also ignore writes while that subregion is enabled.
- R8: A configuration request with `cfg_sec` low or `cfg_priv` low is illegal. Such a write changes nothing, such a read returns 0, and either kind sets the configuration error flag (status bit 1).
- R9: A syndrome capture happens only while both flags are clear. It records {write, privileged, secure, cid[2:0]} in global register 3, bits 5:0, and the address in global register 4. A configuration capture writes 0 to the address register. A data violation wins over a configuration violation in the same cycle. While either flag is set, the record holds its value. Status is read from global register 1, with bit 0 the data flag and bit 1 the configuration flag.
- R10: `irq` is high for exactly one cycle, in the cycle after the violation that sets a flag.
- R11: A legal write of ones to global register 2 clears the matching flags: bit 0 clears the data flag and bit 1 clears the configuration flag.
- R12: Writing 1 to bit 0 of global register 0 sets the global lock. The lock ignores later writes of 0 and stays set until reset. While it is set, all region and subregion writes are ignored, but flag clearing still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_req | input | 1 | Configuration request this cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Region slice [7:4], register [3:0] |
| cfg_wdata | input | 32 | Write data |
| cfg_cid | input | 3 | Compartment of the configuring master |
| cfg_sec | input | 1 | Configuring master is secure |
| cfg_priv | input | 1 | Configuring master is privileged |
| cfg_rdata | output | 32 | Read data, same cycle |
| acc_valid | input | 1 | Data access present |
| acc_addr | input | ADDR_W | Data access address |
| acc_cid | input | 3 | Data access compartment |
| acc_sec | input | 1 | Data access secure |
| acc_priv | input | 1 | Data access privileged |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_allow | output | 1 | Access permitted |
| irq | output | 1 | One-cycle pulse when an error flag sets |

## Verification
Corrupt window registers or whitelists show up on `acc_allow` in the same cycle as the access that touches them. For that reason, a behavioural model is compared against the decision on every clock rather than only at chosen points. A capture that fires twice, or misses its hold, changes the syndrome registers and creates a second `irq` pulse one cycle after the extra violation. Lock bits that fail to hold show up at the next read-back of the register that was written, and at the next access to the affected window.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  typedef struct packed {
    logic [2:0] cid;
    logic       lock;
    logic       wr;
    logic       rd;
    logic       priv;
    logic       sec;
    logic       en;
  } sub_cfg_t;

  function automatic sub_cfg_t word_to_sub(input logic [31:0] w);
    sub_cfg_t s;
    s.en   = w[0];
    s.sec  = w[1];
    s.priv = w[2];
    s.rd   = w[3];
    s.wr   = w[4];
    s.lock = w[5];
    s.cid  = w[10:8];
    return s;
  endfunction

  function automatic logic [31:0] sub_to_word(input sub_cfg_t s);
    return {21'b0, s.cid, 2'b0, s.lock, s.wr, s.rd, s.priv, s.sec, s.en};
  endfunction

  // Base region rule: secure gate, direction whitelist, privilege whitelist.
  function automatic logic base_permit(input logic sec, input logic [7:0] pwl,
                                       input logic [7:0] rwl, input logic [7:0] wwl,
                                       input logic [2:0] cid, input logic asec,
                                       input logic apriv, input logic awr);
    logic dir_ok;
    dir_ok = awr ? wwl[cid] : rwl[cid];
    return (!sec || asec) && dir_ok && (!pwl[cid] || apriv);
  endfunction

  // Subregion rule: single compartment, own attributes, own direction enables.
  function automatic logic sub_permit(input sub_cfg_t s, input logic [2:0] cid,
                                      input logic asec, input logic apriv,
                                      input logic awr);
    logic dir_ok;
    dir_ok = awr ? s.wr : s.rd;
    return (s.cid == cid) && (!s.sec || asec) && (!s.priv || apriv) && dir_ok;
  endfunction

endpackage

// File: rtl/mrf_region.sv
module mrf_region
  import mrf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_reg,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_reg,
  output logic [31:0]       rd_data,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_cid,
  input  logic              acc_sec,
  input  logic              acc_priv,
  input  logic              acc_write,
  output logic              hit,
  output logic              permit
);
  localparam int N_SUB = 2;
  localparam logic [ADDR_W-1:0] GMASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

  logic              en, sec;
  logic [7:0]        pwl, rwl, wwl;
  logic [ADDR_W-1:0] lo, hi;
  sub_cfg_t          sub [N_SUB];
  logic [ADDR_W-1:0] slo [N_SUB];
  logic [ADDR_W-1:0] shi [N_SUB];
  logic [N_SUB-1:0]  sub_in;
  logic [ADDR_W-1:0] wa;

  function automatic logic [ADDR_W-1:0] align_start(input logic [ADDR_W-1:0] a);
    return a & ~GMASK;
  endfunction

  function automatic logic [ADDR_W-1:0] align_end(input logic [ADDR_W-1:0] a);
    return a | GMASK;
  endfunction

  assign wa = wr_data[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en  <= 1'b0;
      sec <= 1'b0;
      pwl <= '0;
      rwl <= '0;
      wwl <= '0;
      lo  <= '0;
      hi  <= '0;
    end else if (wr_en) begin
      case (wr_reg)
        4'd0: begin
          en <= wr_data[0];
          if (wr_data[0]) begin
            sec <= wr_data[1];
            pwl <= wr_data[15:8];
          end
        end
        4'd1: if (!en) lo <= align_start(wa);
        4'd2: if (!en) hi <= align_end(wa);
        4'd3: begin
          rwl <= wr_data[7:0];
          wwl <= wr_data[15:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SUB; k++) begin
        sub[k] <= '0;
        slo[k] <= '0;
        shi[k] <= '0;
      end
    end else begin
      for (int k = 0; k < N_SUB; k++) begin
        if (wr_en && !sub[k].lock) begin
          if (wr_reg == 4'(4 + 3 * k)) sub[k] <= word_to_sub(wr_data);
          if (wr_reg == 4'(5 + 3 * k) && !sub[k].en) slo[k] <= align_start(wa);
          if (wr_reg == 4'(6 + 3 * k) && !sub[k].en) shi[k] <= align_end(wa);
        end
      end
    end
  end

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub_match
    assign sub_in[g] = sub[g].en && (acc_addr >= slo[g]) && (acc_addr <= shi[g]);
  end

  assign hit = en && (acc_addr >= lo) && (acc_addr <= hi);

  always_comb begin
    permit = base_permit(sec, pwl, rwl, wwl, acc_cid, acc_sec, acc_priv, acc_write);
    for (int k = N_SUB - 1; k >= 0; k--) begin
      if (sub_in[k]) permit = sub_permit(sub[k], acc_cid, acc_sec, acc_priv, acc_write);
    end
  end

  always_comb begin
    case (rd_reg)
      4'd0:    rd_data = {16'b0, pwl, 6'b0, sec, en};
      4'd1:    rd_data = 32'(lo);
      4'd2:    rd_data = 32'(hi);
      4'd3:    rd_data = {16'b0, wwl, rwl};
      4'd4:    rd_data = sub_to_word(sub[0]);
      4'd5:    rd_data = 32'(slo[0]);
      4'd6:    rd_data = 32'(shi[0]);
      4'd7:    rd_data = sub_to_word(sub[1]);
      4'd8:    rd_data = 32'(slo[1]);
      4'd9:    rd_data = 32'(shi[1]);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/mrf_syndrome.sv
module mrf_syndrome #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_ev,
  input  logic [5:0]        data_info,
  input  logic [ADDR_W-1:0] data_addr,
  input  logic              cfg_ev,
  input  logic [5:0]        cfg_info,
  input  logic [1:0]        clr_bits,
  output logic              data_err,
  output logic              cfg_err,
  output logic [5:0]        syn_info,
  output logic [ADDR_W-1:0] syn_addr,
  output logic              irq
);
  logic capture;

  assign capture = (data_ev || cfg_ev) && !data_err && !cfg_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_err <= 1'b0;
      cfg_err  <= 1'b0;
      syn_info <= '0;
      syn_addr <= '0;
      irq      <= 1'b0;
    end else begin
      data_err <= (data_err && !clr_bits[0]) || (capture && data_ev);
      cfg_err  <= (cfg_err && !clr_bits[1]) || (capture && !data_ev);
      irq      <= capture;
      if (capture) begin
        syn_info <= data_ev ? data_info : cfg_info;
        syn_addr <= data_ev ? data_addr : '0;
      end
    end
  end

endmodule

// File: rtl/mrf_filter.sv
module mrf_filter
  import mrf_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_cid,
  input  logic              cfg_sec,
  input  logic              cfg_priv,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_cid,
  input  logic              acc_sec,
  input  logic              acc_priv,
  input  logic              acc_write,
  output logic              acc_allow,
  output logic              irq
);
  localparam logic [3:0] GLOBAL_IDX = 4'hF;
  localparam logic [3:0] G_LOCK     = 4'd0;
  localparam logic [3:0] G_STATUS   = 4'd1;
  localparam logic [3:0] G_CLEAR    = 4'd2;
  localparam logic [3:0] G_INFO     = 4'd3;
  localparam logic [3:0] G_ADDR     = 4'd4;

  logic [3:0]             slice;
  logic [3:0]             reg_sel;
  logic                   cfg_legal, cfg_bad, wr_ok, glock;
  logic [NUM_REGIONS-1:0] reg_we, hit, permit;
  logic [31:0]            reg_rd [NUM_REGIONS];
  logic                   any_hit, sel_permit;
  logic [1:0]             clr_bits;
  logic                   data_err, cfg_err;
  logic [5:0]             syn_info;
  logic [ADDR_W-1:0]      syn_addr;
  logic                   data_ev;

  assign slice     = cfg_addr[7:4];
  assign reg_sel   = cfg_addr[3:0];
  assign cfg_legal = cfg_sec && cfg_priv;
  assign cfg_bad   = cfg_req && !cfg_legal;
  assign wr_ok     = cfg_req && cfg_we && cfg_legal;

  always_ff @(posedge clk) begin
    if (!rst_n) glock <= 1'b0;
    else if (wr_ok && slice == GLOBAL_IDX && reg_sel == G_LOCK && cfg_wdata[0]) glock <= 1'b1;
  end

  assign clr_bits = (wr_ok && slice == GLOBAL_IDX && reg_sel == G_CLEAR) ? cfg_wdata[1:0] : 2'b00;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign reg_we[g] = wr_ok && !glock && (slice == 4'(g));
    mrf_region #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_region (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we[g]), .wr_reg(reg_sel), .wr_data(cfg_wdata),
      .rd_reg(reg_sel), .rd_data(reg_rd[g]),
      .acc_addr(acc_addr), .acc_cid(acc_cid), .acc_sec(acc_sec),
      .acc_priv(acc_priv), .acc_write(acc_write),
      .hit(hit[g]), .permit(permit[g])
    );
  end

  // Lowest matching index decides.
  always_comb begin
    any_hit    = 1'b0;
    sel_permit = 1'b0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        any_hit    = 1'b1;
        sel_permit = permit[r];
      end
    end
  end

  assign acc_allow = acc_valid && any_hit && sel_permit;
  assign data_ev   = acc_valid && !acc_allow;

  mrf_syndrome #(.ADDR_W(ADDR_W)) u_syndrome (
    .clk(clk), .rst_n(rst_n),
    .data_ev(data_ev),
    .data_info({acc_write, acc_priv, acc_sec, acc_cid}),
    .data_addr(acc_addr),
    .cfg_ev(cfg_bad),
    .cfg_info({cfg_we, cfg_priv, cfg_sec, cfg_cid}),
    .clr_bits(clr_bits),
    .data_err(data_err), .cfg_err(cfg_err),
    .syn_info(syn_info), .syn_addr(syn_addr), .irq(irq)
  );

  always_comb begin
    cfg_rdata = '0;
    if (cfg_req && cfg_legal) begin
      if (slice == GLOBAL_IDX) begin
        case (reg_sel)
          G_LOCK:   cfg_rdata = {31'b0, glock};
          G_STATUS: cfg_rdata = {30'b0, cfg_err, data_err};
          G_INFO:   cfg_rdata = {26'b0, syn_info};
          G_ADDR:   cfg_rdata = 32'(syn_addr);
          default:  cfg_rdata = '0;
        endcase
      end else begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
          if (slice == 4'(r)) cfg_rdata = reg_rd[r];
        end
      end
    end
  end

endmodule

// File: rtl/mrf_filter_chk.sv
module mrf_filter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_allow,
  input logic              any_hit,
  input logic              cfg_req,
  input logic              cfg_sec,
  input logic              cfg_priv,
  input logic              data_err,
  input logic              cfg_err,
  input logic [1:0]        clr_bits,
  input logic [5:0]        syn_info,
  input logic [ADDR_W-1:0] syn_addr,
  input logic              irq,
  input logic              glock
);

  a_r2_no_match_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !any_hit) |-> !acc_allow);

  a_r8_bad_cfg_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !(cfg_sec && cfg_priv) && !data_err && !cfg_err && !(acc_valid && !acc_allow))
      |=> cfg_err);

  a_r9_syndrome_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_err || cfg_err) && clr_bits == 2'b00) |=> ($stable(syn_info) && $stable(syn_addr)));

  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r10_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (data_err || cfg_err));

  a_r11_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_err && !clr_bits[0]) |=> data_err);

  a_r11_cfg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !clr_bits[1]) |=> cfg_err);

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    glock |=> glock);

endmodule

bind mrf_filter mrf_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_allow(acc_allow), .any_hit(any_hit),
  .cfg_req(cfg_req), .cfg_sec(cfg_sec), .cfg_priv(cfg_priv),
  .data_err(data_err), .cfg_err(cfg_err), .clr_bits(clr_bits),
  .syn_info(syn_info), .syn_addr(syn_addr), .irq(irq), .glock(glock)
);

// File: tb/mrf_filter_bench.sv
`timescale 1ns/1ps
module mrf_filter_bench;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_req = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [2:0]  cfg_cid = '0;
  logic        cfg_sec = 1'b0, cfg_priv = 1'b0;
  logic [31:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [2:0]  acc_cid = '0;
  logic        acc_sec = 1'b0, acc_priv = 1'b0, acc_write = 1'b0;
  logic        acc_allow, irq;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mrf_filter #(.NUM_REGIONS(NR), .ADDR_W(32), .GRAN_BITS(4)) u_mrf_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_cid(cfg_cid), .cfg_sec(cfg_sec), .cfg_priv(cfg_priv), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_cid(acc_cid), .acc_sec(acc_sec),
    .acc_priv(acc_priv), .acc_write(acc_write), .acc_allow(acc_allow), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_en[NR], m_sec[NR], m_pwl[NR], m_lo[NR], m_hi[NR], m_rwl[NR], m_wwl[NR];
  int m_sen[NR][2], m_ssec[NR][2], m_spriv[NR][2], m_srd[NR][2], m_swr[NR][2];
  int m_slk[NR][2], m_scid[NR][2], m_slo[NR][2], m_shi[NR][2];
  bit m_glock, m_derr, m_cerr, m_irq;

  function automatic bit model_allow(bit v, int a, int cid, bit s, bit p, bit w);
    if (!v) return 0;
    for (int r = 0; r < NR; r++) begin
      if (m_en[r] != 0 && a >= m_lo[r] && a <= m_hi[r]) begin
        for (int k = 0; k < 2; k++) begin
          if (m_sen[r][k] != 0 && a >= m_slo[r][k] && a <= m_shi[r][k])
            return (cid == m_scid[r][k]) && (m_ssec[r][k] == 0 || s) &&
                   (m_spriv[r][k] == 0 || p) && ((w ? m_swr[r][k] : m_srd[r][k]) != 0);
        end
        return (m_sec[r] == 0 || s) && ((((w ? m_wwl[r] : m_rwl[r]) >> cid) & 1) == 1) &&
               ((((m_pwl[r] >> cid) & 1) == 0) || p);
      end
    end
    return 0;
  endfunction

  function automatic void model_write(int a, int d);
    int r, k, s, f;
    r = a >> 4;
    k = a & 15;
    if (r == 15) begin
      if (k == 0 && (d & 1) == 1) m_glock = 1;
    end else if (r < NR && !m_glock) begin
      if (k == 0) begin
        m_en[r] = d & 1;
        if ((d & 1) == 1) begin m_sec[r] = (d >> 1) & 1; m_pwl[r] = (d >> 8) & 255; end
      end else if (k == 1) begin
        if (m_en[r] == 0) m_lo[r] = d & ~15;
      end else if (k == 2) begin
        if (m_en[r] == 0) m_hi[r] = d | 15;
      end else if (k == 3) begin
        m_rwl[r] = d & 255; m_wwl[r] = (d >> 8) & 255;
      end else if (k >= 4 && k <= 9) begin
        s = (k - 4) / 3;
        f = (k - 4) % 3;
        if (m_slk[r][s] == 0) begin
          if (f == 0) begin
            m_sen[r][s] = d & 1; m_ssec[r][s] = (d >> 1) & 1; m_spriv[r][s] = (d >> 2) & 1;
            m_srd[r][s] = (d >> 3) & 1; m_swr[r][s] = (d >> 4) & 1;
            m_slk[r][s] = (d >> 5) & 1; m_scid[r][s] = (d >> 8) & 7;
          end else if (m_sen[r][s] == 0) begin
            if (f == 1) m_slo[r][s] = d & ~15;
            else m_shi[r][s] = d | 15;
          end
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    bit de, ce, cap, legal;
    int clr;
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) begin
        m_en[r] = 0; m_sec[r] = 0; m_pwl[r] = 0; m_lo[r] = 0; m_hi[r] = 0;
        m_rwl[r] = 0; m_wwl[r] = 0;
        for (int k = 0; k < 2; k++) begin
          m_sen[r][k] = 0; m_ssec[r][k] = 0; m_spriv[r][k] = 0; m_srd[r][k] = 0;
          m_swr[r][k] = 0; m_slk[r][k] = 0; m_scid[r][k] = 0; m_slo[r][k] = 0; m_shi[r][k] = 0;
        end
      end
      m_glock = 0; m_derr = 0; m_cerr = 0; m_irq = 0;
    end else begin
      legal = cfg_sec && cfg_priv;
      de  = acc_valid && !model_allow(acc_valid, int'(acc_addr), int'(acc_cid), acc_sec, acc_priv, acc_write);
      ce  = cfg_req && !legal;
      cap = (de || ce) && !m_derr && !m_cerr;
      clr = (cfg_req && cfg_we && legal && cfg_addr == 8'hF2) ? int'(cfg_wdata[1:0]) : 0;
      m_derr = (m_derr && (clr & 1) == 0) || (cap && de);
      m_cerr = (m_cerr && (clr & 2) == 0) || (cap && !de);
      m_irq  = cap;
      if (cfg_req && cfg_we && legal) model_write(int'(cfg_addr), int'(cfg_wdata));
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(acc_allow === model_allow(acc_valid, int'(acc_addr), int'(acc_cid), acc_sec, acc_priv, acc_write),
            "R5 per-clock allow vs model", 32'(acc_allow),
            32'(model_allow(acc_valid, int'(acc_addr), int'(acc_cid), acc_sec, acc_priv, acc_write)));
      check(irq === m_irq, "R10 per-clock irq vs model", 32'(irq), 32'(m_irq));
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d,
                           input logic s = 1'b1, input logic p = 1'b1, input logic [2:0] cid = 3'd0);
    cfg_req = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cfg_sec = s; cfg_priv = p; cfg_cid = cid;
    @(posedge clk); #1;
    cfg_req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic [31:0] exp, input string tag,
                          input logic s = 1'b1, input logic p = 1'b1);
    cfg_req = 1'b1; cfg_we = 1'b0; cfg_addr = a; cfg_sec = s; cfg_priv = p; cfg_cid = 3'd0;
    @(negedge clk);
    check(cfg_rdata === exp, tag, cfg_rdata, exp);
    @(posedge clk); #1;
    cfg_req = 1'b0;
  endtask

  task automatic acc_chk(input logic [31:0] a, input logic [2:0] cid, input logic s,
                         input logic p, input logic w, input logic exp, input string tag);
    acc_valid = 1'b1; acc_addr = a; acc_cid = cid; acc_sec = s; acc_priv = p; acc_write = w;
    @(negedge clk);
    check(acc_allow === exp, tag, 32'(acc_allow), 32'(exp));
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "R1 watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cfg_read(8'h00, 32'h0, "R1 region ctrl after reset");
    cfg_read(8'hF0, 32'h0, "R1 global lock after reset");
    cfg_read(8'hF1, 32'h0, "R1 flags after reset");
    acc_chk(32'h100, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R1 deny with nothing enabled");
    // R9 capture of that data violation
    cfg_read(8'hF1, 32'h1, "R9 data flag set");
    cfg_read(8'hF3, 32'h01, "R9 data syndrome info");
    cfg_read(8'hF4, 32'h100, "R9 data syndrome address");
    acc_chk(32'h200, 3'd3, 1'b1, 1'b1, 1'b1, 1'b0, "R2 second violation denied");
    cfg_read(8'hF3, 32'h01, "R9 syndrome held");
    cfg_read(8'hF4, 32'h100, "R9 address held");
    cfg_write(8'hF2, 32'h1);
    cfg_read(8'hF1, 32'h0, "R11 data flag cleared");

    // Region 0: 0x100..0x1FF, read cid1/cid2, write cid1, cid2 needs privilege
    cfg_write(8'h01, 32'h100);
    cfg_write(8'h02, 32'h1FF);
    cfg_write(8'h03, 32'h0206);
    cfg_write(8'h00, 32'h0401);
    acc_chk(32'h100, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 start inclusive read");
    acc_chk(32'h1FF, 3'd1, 1'b0, 1'b0, 1'b1, 1'b1, "R2 end inclusive write");
    acc_chk(32'h200, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 past end denied");
    acc_chk(32'h150, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R5 write whitelist");
    acc_chk(32'h150, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, "R5 privilege whitelist");
    acc_chk(32'h150, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1, "R5 privileged read");
    acc_chk(32'h150, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, "R5 read whitelist");
    cfg_write(8'hF2, 32'h3);

    // R4 window frozen while enabled, disable keeps the rest
    cfg_write(8'h01, 32'h0);
    cfg_read(8'h01, 32'h100, "R4 start frozen while enabled");
    cfg_write(8'h00, 32'h0);
    cfg_read(8'h00, 32'h0400, "R4 disable keeps privilege whitelist");
    acc_chk(32'h100, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R4 disabled region denies");
    cfg_write(8'h00, 32'h0401);

    // R3 alignment on region 2
    cfg_write(8'h21, 32'h123);
    cfg_read(8'h21, 32'h120, "R3 start aligned down");
    cfg_write(8'h22, 32'h131);
    cfg_read(8'h22, 32'h13F, "R3 end aligned up");
    cfg_write(8'h20, 32'h1);
    acc_chk(32'h125, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 lowest index decides");

    // Region 1: secure, all whitelisted
    cfg_write(8'h11, 32'h400);
    cfg_write(8'h12, 32'h4FF);
    cfg_write(8'h13, 32'hFFFF);
    cfg_write(8'h10, 32'h3);
    acc_chk(32'h410, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 secure region non-secure");
    acc_chk(32'h410, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 secure region secure");

    // R6 subregions: A 0x440..0x47F cid5 read; B 0x440..0x4BF cid6 read/write
    cfg_write(8'h15, 32'h440);
    cfg_write(8'h16, 32'h47F);
    cfg_write(8'h14, 32'h0509);
    cfg_write(8'h18, 32'h440);
    cfg_write(8'h19, 32'h4BF);
    cfg_write(8'h17, 32'h0619);
    acc_chk(32'h450, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R6 A overrides secure base");
    acc_chk(32'h450, 3'd5, 1'b0, 1'b0, 1'b1, 1'b0, "R6 A write disabled");
    acc_chk(32'h450, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R6 A other cid");
    acc_chk(32'h450, 3'd6, 1'b0, 1'b0, 1'b0, 1'b0, "R6 A precedence over B");
    acc_chk(32'h490, 3'd6, 1'b0, 1'b0, 1'b1, 1'b1, "R6 B write");
    acc_chk(32'h4C0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R6 base outside subregions");

    // R7 subregion freeze and lock
    cfg_write(8'h15, 32'h0);
    cfg_read(8'h15, 32'h440, "R7 sub start frozen while enabled");
    cfg_write(8'h14, 32'h0529);
    cfg_write(8'h14, 32'h0);
    cfg_read(8'h14, 32'h0529, "R7 locked sub config");
    acc_chk(32'h450, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R7 locked sub still active");
    cfg_write(8'hF2, 32'h3);

    // R8 illegal configuration access
    cfg_write(8'h13, 32'h0, 1'b0, 1'b1, 3'd4);
    cfg_read(8'h13, 32'hFFFF, "R8 illegal write ignored");
    cfg_read(8'hF1, 32'h2, "R8 config flag set");
    cfg_read(8'hF3, 32'h34, "R9 config syndrome info");
    cfg_read(8'hF4, 32'h0, "R9 config syndrome no address");
    cfg_read(8'h13, 32'h0, "R8 illegal read returns zero", 1'b1, 1'b0);
    cfg_write(8'hF2, 32'h2);
    cfg_read(8'hF1, 32'h0, "R11 config flag cleared");

    // R12 global lock
    cfg_write(8'hF0, 32'h1);
    cfg_read(8'hF0, 32'h1, "R12 lock set");
    cfg_write(8'h13, 32'h0);
    cfg_read(8'h13, 32'hFFFF, "R12 whitelist write ignored");
    cfg_write(8'h10, 32'h0);
    acc_chk(32'h410, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R12 disable ignored");
    acc_chk(32'h900, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 unmapped address denied");
    check(irq === 1'b1, "R10 irq after first violation", 32'(irq), 32'd1);
    @(posedge clk); #1;
    check(irq === 1'b0, "R10 irq one cycle", 32'(irq), 32'd0);
    cfg_write(8'hF2, 32'h1);
    cfg_read(8'hF1, 32'h0, "R12 clear works under lock");
    cfg_write(8'hF0, 32'h0);
    cfg_read(8'hF0, 32'h1, "R12 lock stays set");

    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule